// File: doc/BRIEF.md
# Bit-Test Skip Execution Unit

This unit is the execute-stage slice of a small 8-bit core that handles its two conditional bit-test-and-skip instructions. When an instruction is issued, the unit splits the 16-bit word into its fields. It forms a 12-bit data-memory address, either from the bank select value or from the fixed access bank, and reads that register in the same cycle. It then tests one bit of the returned byte and decides whether the successor instruction, which has already been prefetched, must be turned into a no-operation.

The fetch stage tells the unit whether that successor occupies two words. The unit then reports three things one cycle after issue:
- the program-counter increment,
- the number of squashed cycles,
- whether the skip was taken.

It holds `busy` high through every squashed cycle. While `busy` is high it accepts no new instruction. Neither instruction changes any status flag, so the unit has no flag outputs. Other opcodes pass through without any effect.

Top module: `bts_unit`

## Requirements
- R1: The instruction word is decoded as opcode = bits [15:12], bit index = bits [11:9], access bit = bit 8 and file address f = bits [7:0]. Opcode 4'b1011 is the skip-if-clear test and 4'b1010 is the skip-if-set test.
- R2: When the access bit is 1, `rfRdAddr` equals {bankSel, f} and `rfRdEn` is high in the issue cycle.
- R3: When the access bit is 0, `bankSel` is ignored. Values of f below 0x80 address bank 0 ({4'h0, f}) and values from 0x80 up address bank 15 ({4'hF, f}).
- R4: The skip-if-clear opcode takes the skip exactly when bit [bit index] of the read byte is 0.
- R5: The skip-if-set opcode takes the skip exactly when bit [bit index] of the read byte is 1.
- R6: `resValid` pulses for one cycle, in the cycle after issue. It carries `resPcIncr` and `resSquashCnt`:
  - no skip: 1 and 0;
  - skip over a one-word successor: 2 and 1;
  - skip over a two-word successor: 3 and 2.
- R7: Starting the cycle after issue, `busy` is high for exactly `resSquashCnt` cycles, each one a squashed no-operation slot. It is low otherwise.
- R8: An issue while `busy` is high is ignored: `rfRdEn` stays low and no result is produced.
- R9: An issued word whose opcode is neither 4'b1011 nor 4'b1010 causes no read, no result and no busy cycle.
- R10: While reset is asserted and just after it, `resValid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction word is presented for execution |
| instrWord | input | 16 | Instruction word |
| bankSel | input | 4 | Current bank select value |
| nextTwoWord | input | 1 | The prefetched successor is a two-word instruction |
| rfRdData | input | 8 | Register file read data (combinational read) |
| rfRdAddr | output | 12 | Register file read address |
| rfRdEn | output | 1 | Register file read strobe, high in an accepted issue cycle |
| resValid | output | 1 | Result pulse, one cycle after issue |
| resSkip | output | 1 | The skip was taken |
| resPcIncr | output | 2 | Program-counter increment in words |
| resSquashCnt | output | 2 | Number of squashed cycles |
| busy | output | 1 | A squashed cycle is in progress; issues are refused |

## Verification
The bench builds the unit with its default parameters:
- 8-bit file field;
- 4-bit bank select;
- 8-bit data;
- high access bank 15.

With these values, the full 12-bit address space is reachable from a small register-file model. Both halves of the access bank can be told apart from the bank named by `bankSel`, because the model stores different bytes at the aliased addresses. Every bit index is swept under both opcodes, with one-word and two-word successors alternating, so every increment and squash length occurs. Issues made during a squash and foreign opcodes are observed at the read strobe and the result port.

// File: rtl/bts_pkg.sv
package bts_pkg;
  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_SKIP_IF_CLR = 4'b1011;
  localparam logic [OPC_W-1:0] OPC_SKIP_IF_SET = 4'b1010;

  typedef struct packed {
    logic capture;      // accept the presented instruction this cycle
    logic twoWordNext;  // successor length as seen at capture
  } btsStrobes_t;
endpackage

// File: rtl/bts_datapath.sv
module bts_datapath
  import bts_pkg::*;
#(
  parameter int FILE_W    = 8,
  parameter int BANK_W    = 4,
  parameter int DATA_W    = 8,
  parameter int HIGH_BANK = 15,
  localparam int BIT_IDX_W = $clog2(DATA_W),
  localparam int INSTR_W   = OPC_W + BIT_IDX_W + 1 + FILE_W,
  localparam int ADDR_W    = BANK_W + FILE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  btsStrobes_t        strobes,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [BANK_W-1:0]  bankSel,
  input  logic [DATA_W-1:0]  rfRdData,
  output logic               isBitTest,
  output logic               skipCond,
  output logic [ADDR_W-1:0]  rfRdAddr,
  output logic               rfRdEn,
  output logic               resValid,
  output logic               resSkip,
  output logic [1:0]         resPcIncr,
  output logic [1:0]         resSquashCnt
);
  localparam int F_LSB   = 0;
  localparam int ACC_POS = FILE_W;
  localparam int BIT_LSB = FILE_W + 1;
  localparam int OPC_LSB = BIT_LSB + BIT_IDX_W;
  localparam logic [BANK_W-1:0] HIGH_BANK_V = BANK_W'(HIGH_BANK);
  localparam logic [BANK_W-1:0] LOW_BANK_V  = '0;

  logic [OPC_W-1:0]     opcode;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic                 accessSel;
  logic [FILE_W-1:0]    fileAddr;
  logic [BANK_W-1:0]    effBank;
  logic                 testedBit;

  // R1 field split
  assign opcode    = instrWord[OPC_LSB +: OPC_W];
  assign bitIdx    = instrWord[BIT_LSB +: BIT_IDX_W];
  assign accessSel = instrWord[ACC_POS];
  assign fileAddr  = instrWord[F_LSB +: FILE_W];

  assign isBitTest = (opcode == OPC_SKIP_IF_CLR) || (opcode == OPC_SKIP_IF_SET);

  // R2 / R3 bank formation
  always_comb begin
    if (accessSel) effBank = bankSel;
    else if (fileAddr[FILE_W-1]) effBank = HIGH_BANK_V;
    else effBank = LOW_BANK_V;
  end

  assign rfRdAddr  = {effBank, fileAddr};
  assign rfRdEn    = strobes.capture;
  assign testedBit = rfRdData[bitIdx];
  assign skipCond  = (opcode == OPC_SKIP_IF_CLR) ? ~testedBit : testedBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid     <= 1'b0;
      resSkip      <= 1'b0;
      resPcIncr    <= 2'd0;
      resSquashCnt <= 2'd0;
    end else begin
      resValid <= strobes.capture;
      if (strobes.capture) begin
        resSkip <= skipCond;
        if (!skipCond) begin
          resPcIncr    <= 2'd1;
          resSquashCnt <= 2'd0;
        end else if (strobes.twoWordNext) begin
          resPcIncr    <= 2'd3;
          resSquashCnt <= 2'd2;
        end else begin
          resPcIncr    <= 2'd2;
          resSquashCnt <= 2'd1;
        end
      end
    end
  end

  AST_RESULT_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    rfRdEn |=> resValid); // R6
  AST_INCR_MATCHES_CNT: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resPcIncr == resSquashCnt + 2'd1)); // R6
  AST_NOSKIP_NO_SQUASH: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resSkip) |-> (resSquashCnt == 2'd0)); // R4
endmodule

// File: rtl/bts_control.sv
module bts_control
  import bts_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  logic        isBitTest,
  input  logic        skipCond,
  input  logic        nextTwoWord,
  output btsStrobes_t strobes,
  output logic        busy
);
  logic [1:0] squashLeft;

  assign busy                = (squashLeft != 2'd0);
  assign strobes.capture     = issueValid && isBitTest && !busy;  // R8 R9
  assign strobes.twoWordNext = nextTwoWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      squashLeft <= 2'd0;
    end else if (strobes.capture) begin
      if (!skipCond) squashLeft <= 2'd0;
      else if (nextTwoWord) squashLeft <= 2'd2;
      else squashLeft <= 2'd1;
    end else if (busy) begin
      squashLeft <= squashLeft - 2'd1;
    end
  end

  AST_SQUASH_NEVER_THREE: assert property (@(posedge clk) disable iff (!rstN)
    squashLeft != 2'd3); // R7
  AST_SQUASH_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    (squashLeft == 2'd2) |=> (squashLeft == 2'd1)); // R7
endmodule

// File: rtl/bts_unit.sv
module bts_unit
  import bts_pkg::*;
#(
  parameter int FILE_W    = 8,
  parameter int BANK_W    = 4,
  parameter int DATA_W    = 8,
  parameter int HIGH_BANK = 15,
  localparam int BIT_IDX_W = $clog2(DATA_W),
  localparam int INSTR_W   = OPC_W + BIT_IDX_W + 1 + FILE_W,
  localparam int ADDR_W    = BANK_W + FILE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [BANK_W-1:0]  bankSel,
  input  logic               nextTwoWord,
  input  logic [DATA_W-1:0]  rfRdData,
  output logic [ADDR_W-1:0]  rfRdAddr,
  output logic               rfRdEn,
  output logic               resValid,
  output logic               resSkip,
  output logic [1:0]         resPcIncr,
  output logic [1:0]         resSquashCnt,
  output logic               busy
);
  btsStrobes_t strobes;
  logic        isBitTest;
  logic        skipCond;

  bts_control uCtrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .isBitTest(isBitTest),
    .skipCond(skipCond), .nextTwoWord(nextTwoWord), .strobes(strobes), .busy(busy)
  );

  bts_datapath #(
    .FILE_W(FILE_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .HIGH_BANK(HIGH_BANK)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .instrWord(instrWord),
    .bankSel(bankSel), .rfRdData(rfRdData), .isBitTest(isBitTest),
    .skipCond(skipCond), .rfRdAddr(rfRdAddr), .rfRdEn(rfRdEn),
    .resValid(resValid), .resSkip(resSkip), .resPcIncr(resPcIncr),
    .resSquashCnt(resSquashCnt)
  );

  AST_READ_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rfRdEn |-> !busy); // R8
  AST_SKIP_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resSkip) |-> busy); // R7
  AST_NOSKIP_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resSkip) |-> !busy); // R7
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rstN |=> (!resValid && !busy)); // R10
endmodule

// File: tb/tb_bts_unit.sv
module tb_bts_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [3:0]  bankSel = '0;
  logic        nextTwoWord = 1'b0;
  logic [7:0]  rfRdData;
  logic [11:0] rfRdAddr;
  logic        rfRdEn, resValid, resSkip, busy;
  logic [1:0]  resPcIncr, resSquashCnt;

  logic [7:0] regFile [4096];
  assign rfRdData = regFile[rfRdAddr];

  always #10 clk = ~clk;  // 50 MHz

  bts_unit dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instrWord(instrWord),
    .bankSel(bankSel), .nextTwoWord(nextTwoWord), .rfRdData(rfRdData),
    .rfRdAddr(rfRdAddr), .rfRdEn(rfRdEn), .resValid(resValid), .resSkip(resSkip),
    .resPcIncr(resPcIncr), .resSquashCnt(resSquashCnt), .busy(busy)
  );

  typedef struct {
    logic       skip;
    logic [1:0] incr;
    logic [1:0] cnt;
    string      req;
  } expItem_t;
  expItem_t expQ[$];

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [3:0] opc, input int b,
                                     input logic a, input logic [7:0] f);
    return {opc, 3'(b), a, f};
  endfunction

  // Monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expQ.size() == 0) begin
        chk(0, "R9", "unexpected result", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk(resSkip == e.skip, e.req, "resSkip", resSkip, e.skip);
        chk(resPcIncr == e.incr, "R6", "resPcIncr", resPcIncr, e.incr);
        chk(resSquashCnt == e.cnt, "R6", "resSquashCnt", resSquashCnt, e.cnt);
      end
    end
  end

  // Driver: issues one bit-test, pushes expectations, follows busy
  task automatic runTest(input logic [15:0] w, input logic [3:0] bs,
                         input logic two, input bit overlap, input string req);
    logic [11:0] expAddr;
    logic        bitVal, skip;
    logic [1:0]  cnt;
    expItem_t    e;
    if (w[8]) expAddr = {bs, w[7:0]};
    else expAddr = {(w[7] ? 4'hF : 4'h0), w[7:0]};
    bitVal = regFile[expAddr][w[11:9]];
    skip = (w[15:12] == 4'b1011) ? !bitVal : bitVal;
    cnt = !skip ? 2'd0 : (two ? 2'd2 : 2'd1);
    @(negedge clk);
    instrWord = w; bankSel = bs; nextTwoWord = two; issueValid = 1'b1;
    #1;
    chk(rfRdEn == 1'b1, w[8] ? "R2" : "R3", "rfRdEn", rfRdEn, 1);
    chk(rfRdAddr == expAddr, w[8] ? "R2" : "R3", "rfRdAddr", rfRdAddr, expAddr);
    e.skip = skip; e.incr = cnt + 2'd1; e.cnt = cnt; e.req = req;
    expQ.push_back(e);
    for (int k = 1; k <= cnt + 1; k++) begin
      @(negedge clk);
      issueValid = 1'b0;
      nextTwoWord = ~two;
      if (overlap && k == 1 && cnt != 0) begin
        instrWord = mk(4'b1010, 0, 1'b1, 8'h00);
        issueValid = 1'b1;
        #1;
        chk(rfRdEn == 1'b0, "R8", "rfRdEn while busy", rfRdEn, 0);
      end
      chk(busy == (k <= cnt), "R7", "busy", busy, (k <= cnt));
    end
    issueValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) regFile[i] = 8'(i * 7 + 3);
    regFile[12'h045] = 8'h04;
    regFile[12'hFC3] = 8'h80;
    regFile[12'h5C3] = 8'h00;
    regFile[12'h0C3] = 8'h00;
    regFile[12'h012] = 8'h01;
    regFile[12'hA12] = 8'h00;
    regFile[12'h377] = 8'hA5;

    repeat (3) @(negedge clk);
    chk(resValid == 1'b0, "R10", "resValid in reset", resValid, 0);
    chk(busy == 1'b0, "R10", "busy in reset", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(resValid == 1'b0 && busy == 1'b0, "R10", "idle after reset", resValid | busy, 0);

    // R4 skip-if-clear, access bank low half
    runTest(mk(4'b1011, 2, 1'b0, 8'h45), 4'h7, 1'b0, 0, "R4");  // bit set: no skip
    runTest(mk(4'b1011, 3, 1'b0, 8'h45), 4'h7, 1'b0, 0, "R4");  // skip one-word
    runTest(mk(4'b1011, 3, 1'b0, 8'h45), 4'h7, 1'b1, 0, "R4");  // skip two-word
    // R5 skip-if-set
    runTest(mk(4'b1010, 2, 1'b0, 8'h45), 4'h2, 1'b1, 0, "R5");
    runTest(mk(4'b1010, 0, 1'b0, 8'h45), 4'h2, 1'b1, 0, "R5");
    // R3 high access half ignores bankSel
    runTest(mk(4'b1010, 7, 1'b0, 8'hC3), 4'h5, 1'b0, 0, "R3");
    // R2 banked
    runTest(mk(4'b1010, 7, 1'b1, 8'hC3), 4'h5, 1'b0, 0, "R2");
    runTest(mk(4'b1011, 0, 1'b1, 8'h12), 4'hA, 1'b1, 0, "R2");
    runTest(mk(4'b1011, 0, 1'b0, 8'h12), 4'hA, 1'b1, 0, "R3");
    // R1 sweep of every bit index under both opcodes
    for (int b = 0; b < 8; b++) begin
      runTest(mk(4'b1011, b, 1'b1, 8'h77), 4'h3, b[0], 0, "R1");
      runTest(mk(4'b1010, b, 1'b1, 8'h77), 4'h3, ~b[0], 0, "R1");
    end
    // R8 issue during squash is ignored
    runTest(mk(4'b1011, 3, 1'b0, 8'h45), 4'h0, 1'b1, 1, "R8");
    runTest(mk(4'b1010, 2, 1'b0, 8'h45), 4'h0, 1'b0, 1, "R8");
    // R9 foreign opcode
    @(negedge clk);
    instrWord = mk(4'b1001, 3, 1'b0, 8'h45); issueValid = 1'b1;
    #1;
    chk(rfRdEn == 1'b0, "R9", "rfRdEn foreign opcode", rfRdEn, 0);
    @(negedge clk);
    issueValid = 1'b0;
    chk(resValid == 1'b0, "R9", "resValid foreign opcode", resValid, 0);
    chk(busy == 1'b0, "R9", "busy foreign opcode", busy, 0);

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R6", "pending results", expQ.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule